// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command pins of an SDRAM interface and models the controller-visible state of each bank cycle by cycle. It decodes chip select, row strobe, column strobe and write enable into commands. It keeps one state machine per bank and a single device-wide machine for refresh, mode-register loads and precharge of all banks. Parameterised counters time the row-to-column delay, the precharge time, the refresh cycle time and the mode-register delay.

The block is placed beside a memory controller or on a bus monitor. Every accepted command updates the bank and device states. A command that the current states forbid raises a one-cycle flag and changes nothing. Clock enable is assumed high throughout. The block does not model the data path.

Bank state encoding on `bank_state_o` is 0 idle, 1 activating, 2 row active, 3 reading, 4 writing, 5 reading with auto precharge, 6 writing with auto precharge, 7 precharging. Device state encoding on `dev_state_o` is 0 normal, 1 refreshing, 2 mode-register load, 3 precharging all.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Pin code {cs_n,ras_n,cas_n,we_n} with cs_n=1 is inhibit, and 0111 is NOP. Neither one changes any state or raises the flag, and running timers keep counting.
- R2: ACTIVE (0011) to an idle bank puts it in state 1 for TRCD cycles, then in state 2. ACTIVE to a bank that is not idle is flagged.
- R3: READ (0101) and WRITE (0100) with ap_i=0 to a bank in state 2, 3 or 4 give state 3 or 4 for BURST cycles, then state 2. Sent to a bank in any other state, they are flagged.
- R4: READ or WRITE with ap_i=1 gives state 5 or 6 for BURST cycles, then state 7 for TRP cycles, then idle. Any command addressed to that bank before it is idle is flagged.
- R5: PRECHARGE (0010) with ap_i=0 moves a bank in state 2, 3 or 4 to state 7 for TRP cycles, then to idle. Sent to an idle bank it has no effect and is not flagged. Sent to a bank in state 1, 5, 6 or 7 it is flagged.
- R6: PRECHARGE with ap_i=1 is legal only if every bank is in state 0, 2, 3 or 4. It then sends every busy bank to state 7 and holds device state 3 for TRP cycles.
- R7: AUTO REFRESH (0001) and LOAD MODE (0000) are legal only if every bank is idle at that edge. They hold device state 1 for TRC cycles or device state 2 for TMRD cycles, then return to 0.
- R8: While the device state is not 0, every command other than inhibit or NOP is flagged, whatever bank it addresses.
- R9: BURST TERMINATE (0110) acts on the bank of the most recent accepted READ or WRITE. If that bank is in state 3 or 4 it goes to 2. If it is in state 5 or 6 it goes to 7.
- R10: illegal_o is high for exactly the cycle after the edge that registered a forbidden command. That command leaves all states as if it had been a NOP.
- R11: While rst_ni is low, every bank is idle, the device state is 0 and illegal_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| bank_i | input | $clog2(NBANK) | Addressed bank |
| ap_i | input | 1 | Auto precharge on READ/WRITE, all-banks select on PRECHARGE |
| bank_state_o | output | 3*NBANK | Bank k state in bits [3k+2:3k] |
| dev_state_o | output | 2 | Device-wide state |
| illegal_o | output | 1 | Previous command was forbidden |

## Verification
On one edge, a bank timer can expire while a command judged on that bank's old state is registered. The stimulus table provokes this case. It sends AUTO REFRESH on the edge where the last precharge completes, and PRECHARGE of all banks on the edge where the row-to-column delay ends. Both must be flagged, while the bank still reaches its new state. The same command sent one edge later must be accepted. A command to one bank that arrives during a timed transition of another bank is also judged: the busy bank must keep counting, and the addressed bank must not be affected.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [2:0] {
    B_IDLE = 3'd0, B_ACTVG = 3'd1, B_ACTIVE = 3'd2, B_READ = 3'd3,
    B_WRITE = 3'd4, B_RD_AP = 3'd5, B_WR_AP = 3'd6, B_PRECH = 3'd7
  } bank_st_e;

  typedef enum logic [1:0] {
    D_NORM = 2'd0, D_REFRESH = 2'd1, D_MODE = 2'd2, D_PREALL = 2'd3
  } dev_st_e;

  typedef enum logic [3:0] {
    C_INH, C_NOP, C_ACT, C_RD, C_WR, C_BST, C_PRE, C_REF, C_LMR
  } cmd_e;
endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i) cmd_o = C_INH;
    else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd_o = C_NOP;
        3'b011:  cmd_o = C_ACT;
        3'b101:  cmd_o = C_RD;
        3'b100:  cmd_o = C_WR;
        3'b110:  cmd_o = C_BST;
        3'b010:  cmd_o = C_PRE;
        3'b001:  cmd_o = C_REF;
        default: cmd_o = C_LMR;
      endcase
    end
  end
endmodule

// File: rtl/sbt_bank_fsm.sv
module sbt_bank_fsm
  import sbt_pkg::*;
#(
  parameter int unsigned TRCD  = 2,
  parameter int unsigned TRP   = 3,
  parameter int unsigned BURST = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmd_e     cmd_i,
  input  logic     hit_i,     // bank addressed
  input  logic     bst_hit_i, // bank holds the most recent burst
  input  logic     ap_i,
  input  logic     go_i,      // command accepted
  output bank_st_e st_o
);
  localparam int unsigned MAXT = (TRCD > TRP) ? ((TRCD > BURST) ? TRCD : BURST)
                                              : ((TRP > BURST) ? TRP : BURST);
  localparam int unsigned CW = $clog2(MAXT + 1);

  bank_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    unique case (st_q)
      B_ACTVG, B_READ, B_WRITE: if (cnt_q == '0) st_d = B_ACTIVE;
      B_RD_AP, B_WR_AP: if (cnt_q == '0) begin
        st_d  = B_PRECH;
        cnt_d = CW'(TRP - 1);
      end
      B_PRECH: if (cnt_q == '0) st_d = B_IDLE;
      default: ;
    endcase
    if (go_i) begin
      unique case (cmd_i)
        C_ACT: if (hit_i) begin
          st_d  = B_ACTVG;
          cnt_d = CW'(TRCD - 1);
        end
        C_RD, C_WR: if (hit_i) begin
          if (cmd_i == C_RD) st_d = ap_i ? B_RD_AP : B_READ;
          else               st_d = ap_i ? B_WR_AP : B_WRITE;
          cnt_d = CW'(BURST - 1);
        end
        C_PRE: if ((ap_i || hit_i) && st_q != B_IDLE) begin
          st_d  = B_PRECH;
          cnt_d = CW'(TRP - 1);
        end
        C_BST: if (bst_hit_i) begin
          if (st_q == B_READ || st_q == B_WRITE) begin
            st_d  = B_ACTIVE;
            cnt_d = '0;
          end else if (st_q == B_RD_AP || st_q == B_WR_AP) begin
            st_d  = B_PRECH;
            cnt_d = CW'(TRP - 1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;

  assert_act_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == B_ACTIVE && $past(st_q) == B_ACTVG) |-> $past(cnt_q) == '0);

  assert_pre_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == B_IDLE && $past(st_q) == B_PRECH) |-> $past(cnt_q) == '0);

  assert_ap_to_prech_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) inside {B_RD_AP, B_WR_AP} && !(st_q inside {B_RD_AP, B_WR_AP}))
      |-> st_q == B_PRECH);
endmodule

// File: rtl/sbt_dev_fsm.sv
module sbt_dev_fsm
  import sbt_pkg::*;
#(
  parameter int unsigned TRP  = 3,
  parameter int unsigned TRC  = 6,
  parameter int unsigned TMRD = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cmd_e    cmd_i,
  input  logic    ap_i,
  input  logic    go_i,
  output dev_st_e st_o
);
  localparam int unsigned MAXT = (TRC > TRP) ? ((TRC > TMRD) ? TRC : TMRD)
                                             : ((TRP > TMRD) ? TRP : TMRD);
  localparam int unsigned CW = $clog2(MAXT + 1);

  dev_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    if (st_q != D_NORM && cnt_q == '0) st_d = D_NORM;
    if (go_i) begin
      if (cmd_i == C_REF) begin
        st_d  = D_REFRESH;
        cnt_d = CW'(TRC - 1);
      end else if (cmd_i == C_LMR) begin
        st_d  = D_MODE;
        cnt_d = CW'(TMRD - 1);
      end else if (cmd_i == C_PRE && ap_i) begin
        st_d  = D_PREALL;
        cnt_d = CW'(TRP - 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= D_NORM;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;

  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) != D_NORM && $past(cnt_q) != '0) |-> st_q == $past(st_q));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned TRCD  = 2,
  parameter int unsigned TRP   = 3,
  parameter int unsigned TRC   = 6,
  parameter int unsigned TMRD  = 2,
  parameter int unsigned BURST = 4,
  localparam int unsigned BA_W = $clog2(NBANK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               ras_n_i,
  input  logic               cas_n_i,
  input  logic               we_n_i,
  input  logic [BA_W-1:0]    bank_i,
  input  logic               ap_i,
  output logic [3*NBANK-1:0] bank_state_o,
  output logic [1:0]         dev_state_o,
  output logic               illegal_o
);
  cmd_e            cmd;
  dev_st_e         dev_st;
  bank_st_e        st [NBANK];
  bank_st_e        sel_st;
  logic [NBANK-1:0] idle_v, pre_ok_v;
  logic [BA_W-1:0] last_q;
  logic            legal, go, ill_q;

  sbt_cmd_decode u_dec (
    .cs_n_i (cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
    .cmd_o  (cmd)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sbt_bank_fsm #(.TRCD(TRCD), .TRP(TRP), .BURST(BURST)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_i    (cmd),
      .hit_i    (bank_i == BA_W'(g)),
      .bst_hit_i(last_q == BA_W'(g)),
      .ap_i     (ap_i),
      .go_i     (go),
      .st_o     (st[g])
    );
    assign idle_v[g]   = (st[g] == B_IDLE);
    assign pre_ok_v[g] = st[g] inside {B_IDLE, B_ACTIVE, B_READ, B_WRITE};
    assign bank_state_o[3*g +: 3] = st[g];
  end

  sbt_dev_fsm #(.TRP(TRP), .TRC(TRC), .TMRD(TMRD)) u_dev (
    .clk_i (clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .ap_i(ap_i), .go_i(go),
    .st_o  (dev_st)
  );

  assign sel_st = st[bank_i];

  always_comb begin
    unique case (cmd)
      C_INH, C_NOP, C_BST: legal = 1'b1;
      C_ACT:               legal = (sel_st == B_IDLE);
      C_RD, C_WR:          legal = sel_st inside {B_ACTIVE, B_READ, B_WRITE};
      C_PRE:               legal = ap_i ? (&pre_ok_v)
                                        : (sel_st inside {B_IDLE, B_ACTIVE, B_READ, B_WRITE});
      default:             legal = &idle_v; // refresh, mode load
    endcase
    if (dev_st != D_NORM && !(cmd inside {C_INH, C_NOP})) legal = 1'b0;
  end

  assign go = legal && !(cmd inside {C_INH, C_NOP});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ill_q  <= 1'b0;
      last_q <= '0;
    end else begin
      ill_q <= !legal;
      if (go && (cmd == C_RD || cmd == C_WR)) last_q <= bank_i;
    end
  end

  assign illegal_o   = ill_q;
  assign dev_state_o = dev_st;

  assert_ref_needs_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_st inside {D_REFRESH, D_MODE} && $past(dev_st) == D_NORM) |-> $past(&idle_v));

  assert_dev_busy_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_st inside {D_REFRESH, D_MODE}) |-> &idle_v);

  assert_flag_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && $past(dev_st) == D_NORM && $past(cmd) == C_ACT)
      |-> $past(sel_st) != B_IDLE);
endmodule

// File: tb/sim_sdram_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdram_bank_tracker;
  localparam logic [3:0] P_INH = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_BST = 4'b0110,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_LMR = 4'b0000;
  // {pins, bank, ap, ill, b3, b2, b1, b0, dev, req}
  localparam int NV = 58;
  localparam logic [25:0] VEC [NV] = '{
    {P_ACT,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd1,2'd0,4'd2},  // R2
    {P_ACT,2'd0,1'b0,1'b1,3'd0,3'd0,3'd0,3'd1,2'd0,4'd2},  // R2 busy
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd2,2'd0,4'd2},
    {P_RD ,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd3,2'd0,4'd3},  // R3
    {P_ACT,2'd1,1'b0,1'b0,3'd0,3'd0,3'd1,3'd3,2'd0,4'd2},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd1,3'd3,2'd0,4'd1},  // R1
    {P_RD ,2'd1,1'b0,1'b1,3'd0,3'd0,3'd2,3'd3,2'd0,4'd3},  // R3 edge of tRCD
    {P_RD ,2'd1,1'b0,1'b0,3'd0,3'd0,3'd3,3'd2,2'd0,4'd3},
    {P_BST,2'd0,1'b0,1'b0,3'd0,3'd0,3'd2,3'd2,2'd0,4'd9},  // R9
    {P_WR ,2'd0,1'b1,1'b0,3'd0,3'd0,3'd2,3'd6,2'd0,4'd4},  // R4
    {P_RD ,2'd0,1'b0,1'b1,3'd0,3'd0,3'd2,3'd6,2'd0,4'd4},
    {P_RD ,2'd1,1'b0,1'b0,3'd0,3'd0,3'd3,3'd6,2'd0,4'd3},
    {P_REF,2'd0,1'b0,1'b1,3'd0,3'd0,3'd3,3'd6,2'd0,4'd7},  // R7
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd3,3'd7,2'd0,4'd4},
    {P_PRE,2'd0,1'b0,1'b1,3'd0,3'd0,3'd3,3'd7,2'd0,4'd5},  // R5
    {P_PRE,2'd2,1'b0,1'b0,3'd0,3'd0,3'd2,3'd7,2'd0,4'd5},  // R5 idle bank
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd2,3'd0,2'd0,4'd4},
    {P_PRE,2'd1,1'b0,1'b0,3'd0,3'd0,3'd7,3'd0,2'd0,4'd5},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd7,3'd0,2'd0,4'd5},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd7,3'd0,2'd0,4'd5},
    {P_REF,2'd0,1'b0,1'b1,3'd0,3'd0,3'd0,3'd0,2'd0,4'd7},  // R7 same edge
    {P_REF,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd1,4'd7},
    {P_ACT,2'd2,1'b0,1'b1,3'd0,3'd0,3'd0,3'd0,2'd1,4'd8},  // R8
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd1,4'd7},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd1,4'd7},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd1,4'd7},
    {P_INH,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd1,4'd1},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd0,4'd7},
    {P_LMR,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd2,4'd7},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd2,4'd7},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd0,4'd7},
    {P_ACT,2'd3,1'b0,1'b0,3'd1,3'd0,3'd0,3'd0,2'd0,4'd2},
    {P_NOP,2'd0,1'b0,1'b0,3'd1,3'd0,3'd0,3'd0,2'd0,4'd2},
    {P_NOP,2'd0,1'b0,1'b0,3'd2,3'd0,3'd0,3'd0,2'd0,4'd2},
    {P_ACT,2'd2,1'b0,1'b0,3'd2,3'd1,3'd0,3'd0,2'd0,4'd2},
    {P_PRE,2'd0,1'b1,1'b1,3'd2,3'd1,3'd0,3'd0,2'd0,4'd6},  // R6
    {P_PRE,2'd0,1'b1,1'b1,3'd2,3'd2,3'd0,3'd0,2'd0,4'd6},  // R6 same edge
    {P_PRE,2'd0,1'b1,1'b0,3'd7,3'd7,3'd0,3'd0,2'd3,4'd6},
    {P_NOP,2'd0,1'b0,1'b0,3'd7,3'd7,3'd0,3'd0,2'd3,4'd6},
    {P_ACT,2'd0,1'b0,1'b1,3'd7,3'd7,3'd0,3'd0,2'd3,4'd8},  // R8
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd0,4'd6},
    {P_ACT,2'd1,1'b0,1'b0,3'd0,3'd0,3'd1,3'd0,2'd0,4'd2},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd1,3'd0,2'd0,4'd2},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd2,3'd0,2'd0,4'd2},
    {P_RD ,2'd1,1'b1,1'b0,3'd0,3'd0,3'd5,3'd0,2'd0,4'd4},
    {P_BST,2'd0,1'b0,1'b0,3'd0,3'd0,3'd7,3'd0,2'd0,4'd9},  // R9 ap burst
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd7,3'd0,2'd0,4'd4},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd7,3'd0,2'd0,4'd4},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd0,2'd0,4'd4},
    {P_ACT,2'd0,1'b0,1'b0,3'd0,3'd0,3'd0,3'd1,2'd0,4'd2},
    {P_ACT,2'd2,1'b0,1'b0,3'd0,3'd1,3'd0,3'd1,2'd0,4'd2},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd1,3'd0,3'd2,2'd0,4'd2},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd2,3'd0,3'd2,2'd0,4'd2},
    {P_RD ,2'd0,1'b0,1'b0,3'd0,3'd2,3'd0,3'd3,2'd0,4'd3},
    {P_WR ,2'd2,1'b0,1'b0,3'd0,3'd4,3'd0,3'd3,2'd0,4'd3},
    {P_BST,2'd0,1'b0,1'b0,3'd0,3'd2,3'd0,3'd3,2'd0,4'd9},  // R9 most recent
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd2,3'd0,3'd3,2'd0,4'd3},
    {P_NOP,2'd0,1'b0,1'b0,3'd0,3'd2,3'd0,3'd2,2'd0,4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, ap;
  logic [1:0] bank;
  logic [11:0] bst;
  logic [1:0] dst;
  logic ill;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_bank_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .bank_i(bank), .ap_i(ap), .bank_state_o(bst),
    .dev_state_o(dst), .illegal_o(ill)
  );

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {ill,banks,dev} actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] p, input logic [1:0] b, input logic a);
    {cs_n, ras_n, cas_n, we_n} = p;
    bank = b;
    ap   = a;
  endtask

  initial begin
    drive(P_NOP, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 reset", {ill, bst, dst}, 15'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25:22], VEC[i][21:20], VEC[i][19]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), {ill, bst, dst}, VEC[i][18:4]);
    end
    // R10: forbidden ACTIVE on active bank 0 changes nothing, flag drops next cycle
    drive(P_ACT, 2'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R10 flagged", {ill, bst, dst}, {1'b1, 12'o0202, 2'd0});
    drive(P_NOP, 2'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R10 flag drop", {ill, bst, dst}, {1'b0, 12'o0202, 2'd0});
    // R11: reset in the middle of activity
    drive(P_ACT, 2'd3, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(P_NOP, 2'd0, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R11 mid reset", {ill, bst, dst}, 15'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", {ill, bst, dst}, 15'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule